// File: doc/BRIEF.md
# Incremental Hologram Row Phase Engine

This block sweeps one row of a computer-generated hologram for one object point at a time. A single parameter load carries the starting phase of the row, the first phase increment, the constant second difference, an extra phase offset and an amplitude. After the load the engine walks the pixels 0 to NPIX-1 at one pixel per clock. It forms each pixel's phase with additions only, from a running first difference and a running increment. The top bits of that phase address a quarter-wave cosine table. The cosine is scaled by the amplitude and added, with saturation, into a per-pixel accumulator.

Each point's sweep adds onto what earlier sweeps left in the row store. Every pixel result is streamed out with a valid flag and its pixel index. A frame-start pulse empties the store so that a new image can be built. All phases are fractions of one full cycle held in PHASE_W bits and wrap naturally. The cosine table resolution (LUT_AW, COS_W) is a parameter, so table area can be traded against image quality.

Top module: `holo_row_engine`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `prm_ready` is 1 and `pix_valid` is 0.
- R2: Parameters are taken on a clock edge where `prm_valid` and `prm_ready` are both 1. `prm_ready` is 0 from the next cycle until the cycle that presents pixel NPIX-1, and is 1 again in that cycle. Parameter inputs offered while `prm_ready` is 0 are not taken.
- R3: Each accepted load produces exactly NPIX results with `pix_index` 0,1,...,NPIX-1 in consecutive cycles. Pixel 0 appears in the cycle after the fourth rising edge that follows the accepting edge.
- R4: The phase of pixel d is (theta0 + offset + G(d)) mod 2^PHASE_W, where G(d) = d*g1 + d*(d-1)/2*delta, with all values taken as unsigned and wrapped.
- R5: The cosine of a phase comes from its top 2 bits (quadrant q) and the next LUT_AW bits (k). A table T holds M = 2^LUT_AW entries, T[j] = round(CMAX*cos(2*pi*(j+0.5)/(4*M))) with CMAX = 2^(COS_W-1)-1. The cosine is +T[k] for q=0, -T[M-1-k] for q=1, -T[k] for q=2 and +T[M-1-k] for q=3.
- R6: The contribution of a pixel is floor(amp*cos / 2^(COS_W-1)), with `prm_amp` unsigned.
- R7: `pix_value` is the stored value of that pixel plus the contribution, clamped to the range -2^(ACC_W-1) to 2^(ACC_W-1)-1. That result becomes the new stored value.
- R8: A `frame_start` pulse in a cycle where `prm_ready` is 1 sets every stored pixel to 0. A pulse while `prm_ready` is 0 has no effect.
- R9: A `frame_start` pulse in the same cycle as a parameter acceptance clears the store before that sweep adds into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears the row store when idle |
| prm_valid | input | 1 | Parameter set offered |
| prm_ready | output | 1 | Engine idle, parameter set can be taken |
| prm_theta0 | input | PHASE_W | Starting phase of the row (fraction of a cycle) |
| prm_g1 | input | PHASE_W | First phase increment |
| prm_delta | input | PHASE_W | Constant second difference |
| prm_offset | input | PHASE_W | Combined reference and object phase offset |
| prm_amp | input | AMP_W | Unsigned amplitude of the point |
| pix_valid | output | 1 | A pixel result is present |
| pix_index | output | $clog2(NPIX) | Pixel position of the result |
| pix_value | output | ACC_W | Signed accumulated pixel intensity |

## Verification
Results follow a fixed schedule. The engine drops `prm_ready` one cycle after the accepting edge. Pixel 0 is due after the fourth following rising edge, and later pixels follow one per cycle. `prm_ready` returns together with the last pixel. The bench drives inputs on falling edges and waits a counted number of edges before it samples each output on a falling edge. It confirms that `pix_valid` is still low one cycle before pixel 0 is due. It computes every expected value from the closed-form phase, the formula for the cosine table and a saturating model of the row store.

// File: rtl/holo_pkg.sv
package holo_pkg;

  // Quadrant of a wrapped phase, taken from its two top bits.
  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_t;

  // Second and third quadrants give a negative cosine.
  function automatic logic quad_negative(input quad_t q);
    return (q == QUAD_1) || (q == QUAD_2);
  endfunction

  // Odd quadrants walk the quarter table backwards.
  function automatic logic quad_mirrored(input quad_t q);
    return (q == QUAD_1) || (q == QUAD_3);
  endfunction

endpackage

// File: rtl/holo_phase_gen.sv
// Sweeps the pixels of a row. The phase is built by additions only:
// the first difference gains delta each pixel, the increment gains the
// first difference. Only the top OUT_W bits of the phase leave the unit.
module holo_phase_gen #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 8,
  parameter int AMP_W   = 12,
  parameter int NPIX    = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] ld_theta0,
  input  logic [PHASE_W-1:0] ld_g1,
  input  logic [PHASE_W-1:0] ld_delta,
  input  logic [PHASE_W-1:0] ld_offset,
  input  logic [AMP_W-1:0]   ld_amp,
  output logic               busy,
  output logic               o_valid,
  output logic [IDX_W-1:0]   o_idx,
  output logic [OUT_W-1:0]   o_phase,
  output logic [AMP_W-1:0]   o_amp
);

  localparam int              SHIFT = PHASE_W - OUT_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  logic [PHASE_W-1:0] base_r;
  logic [PHASE_W-1:0] gamma_r;
  logic [PHASE_W-1:0] diff_r;
  logic [PHASE_W-1:0] delta_r;
  logic [AMP_W-1:0]   amp_r;
  logic [IDX_W-1:0]   cnt_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      o_valid <= 1'b0;
      o_idx   <= '0;
      o_phase <= '0;
      base_r  <= '0;
      gamma_r <= '0;
      diff_r  <= '0;
      delta_r <= '0;
      amp_r   <= '0;
      cnt_r   <= '0;
    end else begin
      o_valid <= busy;
      if (busy) begin
        o_phase <= OUT_W'((base_r + gamma_r) >> SHIFT);
        o_idx   <= cnt_r;
        gamma_r <= gamma_r + diff_r;
        diff_r  <= diff_r + delta_r;
        cnt_r   <= cnt_r + 1'b1;
        if (cnt_r == LAST) begin
          busy <= 1'b0;
        end
      end else if (load) begin
        busy    <= 1'b1;
        cnt_r   <= '0;
        gamma_r <= '0;
        diff_r  <= ld_g1;
        delta_r <= ld_delta;
        base_r  <= ld_theta0 + ld_offset;
        amp_r   <= ld_amp;
      end
    end
  end

  assign o_amp = amp_r;

endmodule

// File: rtl/holo_cos_rom.sv
// Quarter-wave cosine table sampled at bin centres, so that odd quadrants
// reuse it by index inversion. One cycle of latency; the table has no reset
// so that it maps onto block memory.
module holo_cos_rom
  import holo_pkg::*;
#(
  parameter int LUT_AW = 6,
  parameter int COS_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LUT_AW+1:0]       phase_top,
  output logic signed [COS_W-1:0] cos_val
);

  localparam int  DEPTH  = 1 << LUT_AW;
  localparam int  CMAX   = (1 << (COS_W - 1)) - 1;
  localparam real TWO_PI = 6.283185307179586;

  logic [COS_W-1:0] rom [DEPTH];

  initial begin
    for (int j = 0; j < DEPTH; j++) begin
      rom[j] = COS_W'($rtoi(real'(CMAX) *
                 $cos(TWO_PI * (real'(j) + 0.5) / real'(4 * DEPTH)) + 0.5));
    end
  end

  quad_t             quad;
  logic [LUT_AW-1:0] k_raw;
  logic [LUT_AW-1:0] addr;
  logic [COS_W-1:0]  mag_q;
  logic              neg_q;

  assign quad  = quad_t'(phase_top[LUT_AW+1 -: 2]);
  assign k_raw = phase_top[LUT_AW-1:0];
  assign addr  = quad_mirrored(quad) ? ~k_raw : k_raw;

  always_ff @(posedge clk) begin
    mag_q <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
    end else begin
      neg_q <= quad_negative(quad);
    end
  end

  assign cos_val = neg_q ? (~mag_q + 1'b1) : mag_q;

endmodule

// File: rtl/holo_pix_acc.sv
// Row store with read-modify-write over three stages:
// read, scale, saturating add and write back. A per-pixel written flag
// stands in for clearing the memory itself.
module holo_pix_acc #(
  parameter int NPIX  = 32,
  parameter int IDX_W = 5,
  parameter int AMP_W = 12,
  parameter int COS_W = 10,
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic                    c_valid,
  input  logic [IDX_W-1:0]        c_idx,
  input  logic [AMP_W-1:0]        c_amp,
  input  logic signed [COS_W-1:0] c_val,
  output logic                    inflight,
  output logic                    out_valid,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [ACC_W-1:0] out_value
);

  localparam int PROD_W = AMP_W + 1 + COS_W;
  localparam int WIDE_W = (ACC_W > PROD_W) ? ACC_W : PROD_W;
  localparam int SUM_W  = WIDE_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI =
    {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

  logic [ACC_W-1:0] mem [NPIX];
  logic [NPIX-1:0]  written;

  logic [ACC_W-1:0]         old_q;
  logic                     old_ok;
  logic signed [PROD_W-1:0] prod;
  logic                     p_valid;
  logic [IDX_W-1:0]         p_idx;
  logic signed [PROD_W-1:0] p_contrib;
  logic signed [ACC_W-1:0]  p_old;
  logic signed [SUM_W-1:0]  sum;
  logic signed [ACC_W-1:0]  sat_v;

  // Read stage, aligned with the cosine table read.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      old_q <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      old_ok <= 1'b0;
    end else if (rd_en) begin
      old_ok <= written[rd_idx];
    end
  end

  // Scale stage.
  assign prod = $signed({1'b0, c_amp}) * c_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid   <= 1'b0;
      p_idx     <= '0;
      p_contrib <= '0;
      p_old     <= '0;
    end else begin
      p_valid   <= c_valid;
      p_idx     <= c_idx;
      p_contrib <= prod >>> (COS_W - 1);
      p_old     <= old_ok ? $signed(old_q) : '0;
    end
  end

  // Saturating add and write back.
  assign sum   = SUM_W'(p_old) + SUM_W'(p_contrib);
  assign sat_v = (sum > SAT_HI) ? ACC_W'(SAT_HI) :
                 (sum < SAT_LO) ? ACC_W'(SAT_LO) : ACC_W'(sum);

  always_ff @(posedge clk) begin
    if (p_valid) begin
      mem[p_idx] <= sat_v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_value <= '0;
    end else begin
      out_valid <= p_valid;
      out_idx   <= p_idx;
      out_value <= sat_v;
      if (clear) begin
        written <= '0;
      end else if (p_valid) begin
        written[p_idx] <= 1'b1;
      end
    end
  end

  assign inflight = p_valid;

endmodule

// File: rtl/holo_row_engine.sv
module holo_row_engine #(
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 6,
  parameter int COS_W   = 10,
  parameter int AMP_W   = 12,
  parameter int ACC_W   = 16,
  parameter int NPIX    = 32,
  localparam int IDX_W  = $clog2(NPIX),
  localparam int TOP_W  = LUT_AW + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic                    prm_valid,
  output logic                    prm_ready,
  input  logic [PHASE_W-1:0]      prm_theta0,
  input  logic [PHASE_W-1:0]      prm_g1,
  input  logic [PHASE_W-1:0]      prm_delta,
  input  logic [PHASE_W-1:0]      prm_offset,
  input  logic [AMP_W-1:0]        prm_amp,
  output logic                    pix_valid,
  output logic [IDX_W-1:0]        pix_index,
  output logic signed [ACC_W-1:0] pix_value
);

  logic               load;
  logic               clear;
  logic               gen_busy;
  logic               g_valid;
  logic [IDX_W-1:0]   g_idx;
  logic [TOP_W-1:0]   g_phase;
  logic [AMP_W-1:0]   g_amp;
  logic               s2_valid;
  logic [IDX_W-1:0]   s2_idx;
  logic [AMP_W-1:0]   s2_amp;
  logic signed [COS_W-1:0] cos_v;
  logic               acc_inflight;

  assign prm_ready = ~(gen_busy | g_valid | s2_valid | acc_inflight);
  assign load      = prm_valid & prm_ready;
  assign clear     = frame_start & prm_ready;

  holo_phase_gen #(
    .PHASE_W (PHASE_W),
    .OUT_W   (TOP_W),
    .AMP_W   (AMP_W),
    .NPIX    (NPIX),
    .IDX_W   (IDX_W)
  ) u_gen (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ld_theta0 (prm_theta0),
    .ld_g1     (prm_g1),
    .ld_delta  (prm_delta),
    .ld_offset (prm_offset),
    .ld_amp    (prm_amp),
    .busy      (gen_busy),
    .o_valid   (g_valid),
    .o_idx     (g_idx),
    .o_phase   (g_phase),
    .o_amp     (g_amp)
  );

  holo_cos_rom #(
    .LUT_AW (LUT_AW),
    .COS_W  (COS_W)
  ) u_rom (
    .clk       (clk),
    .rst       (rst),
    .phase_top (g_phase),
    .cos_val   (cos_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_idx   <= '0;
      s2_amp   <= '0;
    end else begin
      s2_valid <= g_valid;
      s2_idx   <= g_idx;
      s2_amp   <= g_amp;
    end
  end

  holo_pix_acc #(
    .NPIX  (NPIX),
    .IDX_W (IDX_W),
    .AMP_W (AMP_W),
    .COS_W (COS_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .rd_en     (g_valid),
    .rd_idx    (g_idx),
    .c_valid   (s2_valid),
    .c_idx     (s2_idx),
    .c_amp     (s2_amp),
    .c_val     (cos_v),
    .inflight  (acc_inflight),
    .out_valid (pix_valid),
    .out_idx   (pix_index),
    .out_value (pix_value)
  );

endmodule

// File: rtl/holo_row_engine_chk.sv
module holo_row_engine_chk #(
  parameter int NPIX  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             prm_valid,
  input logic             prm_ready,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_index
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  // R1: idle right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prm_ready && !pix_valid));

  // R2: an accepted load closes the parameter port
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (prm_valid && prm_ready) |=> !prm_ready);

  // R2: no load while pixels other than the last are still coming out
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_index != LAST) |-> !prm_ready);

  // R3: indices rise by one each cycle within a sweep
  a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_index != LAST) |=>
      (pix_valid && pix_index == IDX_W'($past(pix_index) + 1'b1)));

  // R3: every sweep begins at pixel 0
  a_r3_first_index: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_valid) |-> (pix_index == '0));

endmodule

bind holo_row_engine holo_row_engine_chk #(
  .NPIX  (NPIX),
  .IDX_W (IDX_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .prm_valid (prm_valid),
  .prm_ready (prm_ready),
  .pix_valid (pix_valid),
  .pix_index (pix_index)
);

// File: tb/test_holo_row_engine.sv
module test_holo_row_engine;

  localparam int NPIX   = 32;
  localparam int ACC_HI = 32767;
  localparam int ACC_LO = -32768;

  typedef struct packed {
    logic        clr;
    logic [15:0] th;
    logic [15:0] g1;
    logic [15:0] dl;
    logic [15:0] off;
    logic [11:0] amp;
  } vec_t;

  // Stimulus table; expected values come from the model below.
  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 12'd1000},
    '{1'b0, 16'h1000, 16'h0100, 16'h0040, 16'h2000, 12'd4095},
    '{1'b0, 16'hF000, 16'h3000, 16'hF800, 16'h8000, 12'd2048},
    '{1'b1, 16'h4000, 16'h0777, 16'h0123, 16'h1111, 12'd0},
    '{1'b0, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 12'd4095},
    '{1'b0, 16'h3A5C, 16'hC3E1, 16'h0F0F, 16'h7777, 12'd1234}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        prm_valid = 1'b0;
  logic        prm_ready;
  logic [15:0] prm_theta0 = '0;
  logic [15:0] prm_g1 = '0;
  logic [15:0] prm_delta = '0;
  logic [15:0] prm_offset = '0;
  logic [11:0] prm_amp = '0;
  logic        pix_valid;
  logic [4:0]  pix_index;
  logic signed [15:0] pix_value;

  int n_tests = 0;
  int n_fail  = 0;
  int acc [NPIX];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  holo_row_engine i_holo_row_engine (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .prm_valid  (prm_valid),
    .prm_ready  (prm_ready),
    .prm_theta0 (prm_theta0),
    .prm_g1     (prm_g1),
    .prm_delta  (prm_delta),
    .prm_offset (prm_offset),
    .prm_amp    (prm_amp),
    .pix_valid  (pix_valid),
    .pix_index  (pix_index),
    .pix_value  (pix_value)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: quarter-table entry by formula
  function automatic int tbl(input int j);
    return $rtoi(511.0 * $cos(6.283185307179586 * (real'(j) + 0.5) / 256.0) + 0.5);
  endfunction

  function automatic int cos_ref(input int ph);
    int q = (ph >> 14) & 3;
    int k = (ph >> 8) & 63;
    case (q)
      0:       return  tbl(k);
      1:       return -tbl(63 - k);
      2:       return -tbl(k);
      default: return  tbl(63 - k);
    endcase
  endfunction

  // R4 closed form, R6 scaling, R7 clamp
  function automatic int pix_ref(input vec_t v, input int d, input int old);
    longint g;
    int ph, c, contrib, s;
    g  = longint'(d) * longint'(v.g1) +
         (longint'(d) * longint'(d - 1) / 2) * longint'(v.dl);
    ph = int'((longint'(v.th) + longint'(v.off) + g) & 64'hFFFF);
    c  = cos_ref(ph);
    contrib = (int'(v.amp) * c) >>> 9;
    s = old + contrib;
    if (s > ACC_HI) s = ACC_HI;
    if (s < ACC_LO) s = ACC_LO;
    return s;
  endfunction

  task automatic run_sweep(input vec_t v, input bit noise);
    @(negedge clk);
    check("R2 ready before load", int'(prm_ready), 1);
    prm_valid   = 1'b1;
    prm_theta0  = v.th;
    prm_g1      = v.g1;
    prm_delta   = v.dl;
    prm_offset  = v.off;
    prm_amp     = v.amp;
    frame_start = v.clr;
    @(posedge clk);
    @(negedge clk);
    prm_valid   = 1'b0;
    frame_start = 1'b0;
    check("R2 ready low after load", int'(prm_ready), 0);
    if (v.clr) begin
      for (int i = 0; i < NPIX; i++) acc[i] = 0;  // R8 R9
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 no output before latency", int'(pix_valid), 0);
    for (int d = 0; d < NPIX; d++) begin
      @(negedge clk);
      check("R3 valid", int'(pix_valid), 1);
      check("R3 index", int'(pix_index), d);
      acc[d] = pix_ref(v, d, acc[d]);
      check("R4 R5 R6 R7 value", int'(pix_value), acc[d]);
      if (noise && d >= 1 && d <= 3) begin
        // R2 R8: offers and clear pulses while busy must be ignored
        prm_valid   = 1'b1;
        prm_theta0  = 16'h5555;
        prm_amp     = 12'd4095;
        frame_start = 1'b1;
      end else if (noise && d == 4) begin
        prm_valid   = 1'b0;
        frame_start = 1'b0;
      end
    end
    check("R2 ready with last pixel", int'(prm_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < NPIX; i++) acc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", int'(prm_ready), 1);
    check("R1 no output in reset", int'(pix_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(prm_ready), 1);
    check("R1 no output after reset", int'(pix_valid), 0);

    // Table walk: R4 R5 R6 R7 with R9 clears on vectors 0 and 3
    for (int i = 0; i < NVEC; i++) begin
      run_sweep(VEC[i], i == 2);
    end

    // R7 positive clamp: ninth full-scale add saturates
    run_sweep('{1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 12'd4095}, 1'b0);
    for (int i = 0; i < 8; i++) begin
      run_sweep('{1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 12'd4095}, 1'b0);
    end
    check("R7 positive clamp", acc[0], ACC_HI);

    // R7 negative clamp
    run_sweep('{1'b1, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 12'd4095}, 1'b0);
    for (int i = 0; i < 8; i++) begin
      run_sweep('{1'b0, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 12'd4095}, 1'b0);
    end
    check("R7 negative clamp", acc[5], ACC_LO);

    // R8: idle clear pulse alone, then a zero-amplitude sweep shows the store
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < NPIX; i++) acc[i] = 0;
    run_sweep('{1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 12'd0}, 1'b0);

    // R8: mid-sweep clear ignored; next zero-amplitude sweep reads the store back
    run_sweep('{1'b0, 16'h2468, 16'h1357, 16'h0246, 16'h0000, 12'd3000}, 1'b1);
    run_sweep('{1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 12'd0}, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule